// File: doc/BRIEF.md
# Poll-Mode Priority Interrupt Controller

This block collects eight interrupt request lines and decides which one the host should service next. The host never takes part in an acknowledge cycle. Instead it writes a poll command and then reads a status byte. That read names the winning level and moves it into service.

Software sets the controller up through a byte-wide register window with two addresses. A start word on address 0 opens a short setup sequence on address 1. After that, address-1 writes load the mask. Address-0 command words do three kinds of work:

- finish service, either for one named level or for the most urgent level;
- rotate the priority ring;
- choose what an address-0 read returns, or switch special mask mode on and off.

A request that disappears after the interrupt line went high still gets an answer when polled. The answer reports level 7 and leaves level 7 out of service, so software can tell it is spurious.

The register window is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. For a read, `rdata` is valid combinationally in the same cycle that `rd_en` is high. Any side effect of that read, such as a poll acknowledge, happens at the closing edge.

Top module: `irq_poll_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0, the mask is all ones (an address-1 read returns 0xFF), no level is pending or in service, level 7 is the lowest priority, and address-0 reads return the pending-request byte.
- R2: An address-0 write with bit 4 set starts setup. It clears the mask, in-service bits, special mask mode and any armed poll, makes level 7 lowest, and selects pending-request reads. Bit 0 of that word says whether a third setup word follows. The next address-1 writes go to `vec_base`, then to `casc_cfg`, then (if announced) to the mode word. Only later address-1 writes load the mask.
- R3: A rising edge on `irq_req[i]` sets pending bit i one edge later. The bit clears when the line drops before service or when the level is granted. A line held high after grant does not set the bit again.
- R4: A mask bit of 1 keeps the same-index request from winning, so it cannot raise `irq_out` or be granted.
- R5: Priority is a ring that starts just above the lowest level. Command 0xC0|L makes level L lowest. For example, 0xC2 gives the order 3,4,5,6,7,0,1,2.
- R6: Command 0x0C arms a poll. The next address-0 read returns {1, 0000, level} for the winner, sets that level in service and clears its pending bit. With no winner and `irq_out` low, the read returns 0x00. The read disarms the poll.
- R7: Command 0x0A selects pending-request reads on address 0. Command 0x0B selects in-service reads.
- R8: A level in service blocks every request of equal or lower priority. Requests of higher priority still win.
- R9: Command 0x60|L clears only in-service bit L. This lets a blocked lower request win.
- R10: Command 0x20 clears the highest-priority in-service bit.
- R11: Command 0xA0 does what 0x20 does and also makes the cleared level lowest. Command 0xE0|L clears in-service bit L and makes L lowest. Command codes 000, 010 and 100 in bits 7:5 have no effect.
- R12: Command 0x68 enables special mask mode and 0x48 disables it. In that mode a masked in-service level no longer blocks lower-priority requests.
- R13: Suppose `irq_out` is high and the winner vanishes before the poll, because its line dropped or it was masked. The poll then returns 0x87 and leaves the in-service register unchanged.
- R14: `irq_out` rises on the second edge after a winner appears. It stays high until an armed poll read, which drops it for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Request lines, edge detected |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| irq_out | output | 1 | Interrupt to the host |
| vec_base | output | 8 | First setup word as stored |
| casc_cfg | output | 8 | Second setup word as stored |

## Verification
The bench goes after these corner cases, each of which a wrong design would get visibly wrong:

- **Priority rotation.** A design that ignores the rotated base would report 0x81 instead of 0x84 after 0xC2.
- **Spurious poll.** A design that drops `irq_out` when the request vanishes, or that marks level 7 in service anyway, would fail the 0x87 check or the in-service read that follows it.
- **Special mask mode.** A design that lets a masked in-service level keep blocking would never raise `irq_out` for level 6.
- **Grant of a held line.** A design that re-latches a line still held high after grant would show it again as pending.

Random traffic on lines, masks, commands and re-setup is compared against a cycle model built from these rules.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  // setup progress after a start word
  typedef enum logic [1:0] {
    CFG_RUN  = 2'd0,
    CFG_BASE = 2'd1,
    CFG_CASC = 2'd2,
    CFG_MODE = 2'd3
  } cfg_state_e;

  // operation field, bits 7:5 of an address-0 command with bits 4:3 clear
  localparam logic [2:0] CMD_NS_EOI  = 3'b001;
  localparam logic [2:0] CMD_SP_EOI  = 3'b011;
  localparam logic [2:0] CMD_ROT_NS  = 3'b101;
  localparam logic [2:0] CMD_SET_LOW = 3'b110;
  localparam logic [2:0] CMD_ROT_SP  = 3'b111;

endpackage

// File: rtl/ipc_req_edge.sv
module ipc_req_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] grant,
  output logic [N-1:0] irr
);

  logic [N-1:0] req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= '0;
      irr   <= '0;
    end else begin
      req_d <= req;
      irr   <= ((irr & req) | (req & ~req_d)) & ~grant;
    end
  end

  // R3
  irr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~$past(irr) & ~$past(req)) == '0));

  // R6
  irr_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((irr & $past(grant)) == '0));

endmodule

// File: rtl/ipc_prio_pick.sv
module ipc_prio_pick #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] lowest,
  output logic          hit,
  output logic [LW-1:0] lvl
);

  // scan from least to most urgent so the most urgent hit is kept last
  logic [LW-1:0] ix;

  always_comb begin
    hit = 1'b0;
    lvl = '0;
    ix  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      ix = lowest + LW'(k + 1);
      if (vec[ix]) begin
        hit = 1'b1;
        lvl = ix;
      end
    end
  end

endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import ipc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_req,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         addr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  output logic         irq_out,
  output logic [7:0]   vec_base,
  output logic [7:0]   casc_cfg
);

  localparam int LW = $clog2(N);
  localparam int NP = 3;           // candidate, blocking, in-service picks
  localparam int ZW = 8 - 1 - LW;  // zero field in the poll byte

  cfg_state_e    cfg_st;
  logic          need_mode;
  logic [N-1:0]  mask, isr, irr, isr_clr, grant;
  logic [LW-1:0] lowest, low_nxt;
  logic          smm, rd_isr, poll_arm, irq_q;

  // strobe decode
  logic wr0, wr1, rd0, is_icw1, is_ocw2, is_ocw3, poll_take;
  assign wr0       = wr_en & ~addr;
  assign wr1       = wr_en & addr;
  assign rd0       = rd_en & ~addr;
  assign is_icw1   = wr0 & wdata[4];
  assign is_ocw2   = wr0 & ~wdata[4] & ~wdata[3];
  assign is_ocw3   = wr0 & ~wdata[4] & wdata[3];
  assign poll_take = rd0 & poll_arm;

  ipc_req_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .grant(grant), .irr(irr)
  );

  // priority picks over three vectors
  logic [N-1:0]  pick_vec [NP];
  logic          pick_hit [NP];
  logic [LW-1:0] pick_lvl [NP];

  assign pick_vec[0] = irr & ~mask;
  assign pick_vec[1] = smm ? (isr & ~mask) : isr;
  assign pick_vec[2] = isr;

  for (genvar g = 0; g < NP; g++) begin : g_pick
    ipc_prio_pick #(.N(N)) u_pick (
      .vec(pick_vec[g]), .lowest(lowest), .hit(pick_hit[g]), .lvl(pick_lvl[g])
    );
  end

  logic [LW-1:0] rank_c, rank_s;
  logic          win_v;
  assign rank_c = pick_lvl[0] - lowest - LW'(1);
  assign rank_s = pick_lvl[1] - lowest - LW'(1);
  assign win_v  = pick_hit[0] & (~pick_hit[1] | (rank_c < rank_s));
  assign grant  = (poll_take & win_v) ? (N'(1) << pick_lvl[0]) : '0;

  // in-service clears and priority base
  always_comb begin
    isr_clr = '0;
    low_nxt = lowest;
    if (is_icw1) begin
      isr_clr = '1;
      low_nxt = LW'(N - 1);
    end else if (is_ocw2) begin
      case (wdata[7:5])
        CMD_NS_EOI:  if (pick_hit[2]) isr_clr[pick_lvl[2]] = 1'b1;
        CMD_ROT_NS:  if (pick_hit[2]) begin
                       isr_clr[pick_lvl[2]] = 1'b1;
                       low_nxt = pick_lvl[2];
                     end
        CMD_SP_EOI:  isr_clr[wdata[LW-1:0]] = 1'b1;
        CMD_ROT_SP:  begin
                       isr_clr[wdata[LW-1:0]] = 1'b1;
                       low_nxt = wdata[LW-1:0];
                     end
        CMD_SET_LOW: low_nxt = wdata[LW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_st    <= CFG_RUN;
      need_mode <= 1'b0;
      mask      <= '1;
      isr       <= '0;
      lowest    <= LW'(N - 1);
      smm       <= 1'b0;
      rd_isr    <= 1'b0;
      poll_arm  <= 1'b0;
      irq_q     <= 1'b0;
      vec_base  <= '0;
      casc_cfg  <= '0;
    end else begin
      isr    <= (isr & ~isr_clr) | grant;
      lowest <= low_nxt;
      irq_q  <= poll_take ? 1'b0 : (irq_q | win_v);
      if (poll_take) poll_arm <= 1'b0;
      if (is_icw1) begin
        cfg_st    <= CFG_BASE;
        need_mode <= wdata[0];
        mask      <= '0;
        smm       <= 1'b0;
        rd_isr    <= 1'b0;
        poll_arm  <= 1'b0;
      end
      if (is_ocw3) begin
        if (wdata[2]) poll_arm <= 1'b1;
        if (wdata[1]) rd_isr   <= wdata[0];
        if (wdata[6]) smm      <= wdata[5];
      end
      if (wr1) begin
        case (cfg_st)
          CFG_BASE: begin
            vec_base <= wdata;
            cfg_st   <= CFG_CASC;
          end
          CFG_CASC: begin
            casc_cfg <= wdata;
            cfg_st   <= need_mode ? CFG_MODE : CFG_RUN;
          end
          CFG_MODE: cfg_st <= CFG_RUN;
          default:  mask   <= wdata[N-1:0];
        endcase
      end
    end
  end

  // read path
  logic [7:0] poll_byte;
  always_comb begin
    if (win_v)      poll_byte = {1'b1, {ZW{1'b0}}, pick_lvl[0]};
    else if (irq_q) poll_byte = {1'b1, {ZW{1'b0}}, {LW{1'b1}}};
    else            poll_byte = '0;
    if (addr)          rdata = 8'(mask);
    else if (poll_arm) rdata = poll_byte;
    else if (rd_isr)   rdata = 8'(isr);
    else               rdata = 8'(irr);
  end

  assign irq_out = irq_q;

  // R2
  start_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_icw1 |=> (mask == '0 && isr == '0));

  // R14
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !poll_take) |=> irq_out);

  // R13
  spur_isr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !win_v && !wr_en) |=> (isr == $past(isr)));

  // R10
  ns_eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ocw2 && wdata[7:5] == CMD_NS_EOI && isr != '0 && !poll_take)
      |=> ($countones(isr) + 1 == $countones($past(isr))));

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

endmodule

// File: tb/irq_poll_ctrl_tb.sv
`timescale 1ns/1ps
module irq_poll_ctrl_tb;

  localparam time TCK = 4ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec_base, casc_cfg;
  logic       irq_out;

  always #(TCK/2) clk = ~clk;

  irq_poll_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
    .vec_base(vec_base), .casc_cfg(casc_cfg)
  );

  int unsigned vecs = 0, miss = 0;
  bit          done = 1'b0;
  logic [7:0]  last_rd;

  // cycle model built from the requirements
  logic [7:0] m_req = '0, m_reqd = '0, m_irr = '0, m_isr = '0, m_mask = 8'hFF;
  logic [7:0] m_vb = '0, m_cc = '0;
  logic [2:0] m_low = 3'd7;
  logic       m_smm = 0, m_irq = 0, m_poll = 0, m_rdisr = 0, m_need4 = 0;
  logic [1:0] m_st = 2'd0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] m_pick(logic [7:0] v);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] ix;
      ix = m_low + 3'(k + 1);
      if (v[ix]) return {1'b1, ix};
    end
    return 4'h0;
  endfunction

  function automatic logic [2:0] m_rank(logic [2:0] l);
    return l - m_low - 3'd1;
  endfunction

  function automatic logic [3:0] m_win();
    logic [3:0] c, s;
    c = m_pick(m_irr & ~m_mask);
    s = m_pick(m_smm ? (m_isr & ~m_mask) : m_isr);
    if (c[3] && (!s[3] || m_rank(c[2:0]) < m_rank(s[2:0]))) return c;
    return 4'h0;
  endfunction

  task automatic cyc(bit w, bit r, bit a, logic [7:0] d, string tag);
    logic [3:0] wn, t;
    logic [7:0] ex, nirr, nisr;
    logic [2:0] nlow;
    logic       nirq;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; irq_req = m_req;
    #1;
    wn = m_win();
    if (r) begin
      if (a) ex = m_mask;
      else if (m_poll) ex = wn[3] ? {5'b10000, wn[2:0]} : (m_irq ? 8'h87 : 8'h00);
      else ex = m_rdisr ? m_isr : m_irr;
      chk(tag, rdata, ex);
      last_rd = rdata;
    end
    chk("R14", {7'b0, irq_out}, {7'b0, m_irq});
    nirr = (m_irr & m_req) | (m_req & ~m_reqd);
    nisr = m_isr; nlow = m_low; nirq = m_irq | wn[3];
    if (r && !a && m_poll) begin
      nirq = 1'b0; m_poll = 1'b0;
      if (wn[3]) begin nisr[wn[2:0]] = 1'b1; nirr[wn[2:0]] = 1'b0; end
    end
    if (w && !a) begin
      if (d[4]) begin
        m_st = 2'd1; m_need4 = d[0]; m_mask = '0; nlow = 3'd7;
        m_smm = 0; m_rdisr = 0; m_poll = 0; nisr = '0;
      end else if (!d[3]) begin
        t = m_pick(m_isr);
        case (d[7:5])
          3'b001: if (t[3]) nisr[t[2:0]] = 1'b0;
          3'b101: if (t[3]) begin nisr[t[2:0]] = 1'b0; nlow = t[2:0]; end
          3'b011: nisr[d[2:0]] = 1'b0;
          3'b111: begin nisr[d[2:0]] = 1'b0; nlow = d[2:0]; end
          3'b110: nlow = d[2:0];
          default: ;
        endcase
      end else begin
        if (d[2]) m_poll = 1'b1;
        if (d[1]) m_rdisr = d[0];
        if (d[6]) m_smm = d[5];
      end
    end
    if (w && a) begin
      case (m_st)
        2'd1: begin m_vb = d; m_st = 2'd2; end
        2'd2: begin m_cc = d; m_st = m_need4 ? 2'd3 : 2'd0; end
        2'd3: m_st = 2'd0;
        default: m_mask = d;
      endcase
    end
    m_irr = nirr; m_isr = nisr; m_low = nlow; m_irq = nirq; m_reqd = m_req;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, tag);
  endtask
  task automatic wr(bit a, logic [7:0] d, string tag);
    cyc(1, 0, a, d, tag);
  endtask
  task automatic rd(bit a, string tag);
    cyc(0, 1, a, 8'h00, tag);
  endtask
  task automatic irq_is(string tag, bit e);
    chk(tag, {7'b0, irq_out}, {7'b0, e});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1, "R1"); chk("R1", last_rd, 8'hFF);
    rd(0, "R1"); chk("R1", last_rd, 8'h00);
    irq_is("R1", 0);

    // R2 setup sequence with mode word
    wr(0, 8'h11, "R2"); wr(1, 8'h20, "R2"); wr(1, 8'h04, "R2"); wr(1, 8'h01, "R2");
    chk("R2", vec_base, 8'h20); chk("R2", casc_cfg, 8'h04);
    rd(1, "R2"); chk("R2", last_rd, 8'h00);
    wr(1, 8'hFF, "R2"); rd(1, "R2"); chk("R2", last_rd, 8'hFF);
    wr(1, 8'h00, "R4");

    // R6 R5 default order, R7 ISR read, R3 held line not re-latched
    m_req = 8'h28; idle(3, "R14"); irq_is("R14", 1);
    wr(0, 8'h0C, "R6"); rd(0, "R6"); chk("R6", last_rd, 8'h83);
    wr(0, 8'h0B, "R7"); rd(0, "R7"); chk("R7", last_rd, 8'h08);
    wr(0, 8'h0A, "R7"); rd(0, "R3"); chk("R3", last_rd, 8'h20);
    idle(2, "R8"); irq_is("R8", 0);

    // R9 specific EOI releases lower request
    wr(0, 8'h63, "R9"); idle(2, "R9"); irq_is("R9", 1);
    wr(0, 8'h0C, "R9"); rd(0, "R9"); chk("R9", last_rd, 8'h85);

    // R10 non-specific EOI
    wr(0, 8'h20, "R10"); wr(0, 8'h0B, "R10"); rd(0, "R10"); chk("R10", last_rd, 8'h00);

    // R5 rotation by 0xC2
    m_req = 8'h00; idle(2, "R3");
    wr(0, 8'hC2, "R5"); m_req = 8'h12; idle(3, "R5");
    wr(0, 8'h0C, "R5"); rd(0, "R5"); chk("R5", last_rd, 8'h84);

    // R4 mask blocks, empty poll
    wr(1, 8'h02, "R4"); wr(0, 8'h64, "R4"); idle(2, "R4"); irq_is("R4", 0);
    wr(0, 8'h0C, "R6"); rd(0, "R6"); chk("R6", last_rd, 8'h00);

    // R13 spurious after line withdrawn
    wr(1, 8'h00, "R13"); idle(2, "R13"); irq_is("R13", 1);
    m_req = 8'h00; idle(2, "R13"); irq_is("R13", 1);
    wr(0, 8'h0C, "R13"); rd(0, "R13"); chk("R13", last_rd, 8'h87);
    wr(0, 8'h0B, "R13"); rd(0, "R13"); chk("R13", last_rd, 8'h00);

    // R12 special mask mode
    wr(0, 8'hC7, "R5"); m_req = 8'h44; idle(3, "R12");
    wr(0, 8'h0C, "R12"); rd(0, "R12"); chk("R12", last_rd, 8'h82);
    wr(1, 8'h04, "R12"); idle(2, "R12"); irq_is("R12", 0);
    wr(0, 8'h68, "R12"); idle(2, "R12"); irq_is("R12", 1);
    wr(0, 8'h0C, "R12"); rd(0, "R12"); chk("R12", last_rd, 8'h86);
    rd(0, "R12"); chk("R12", last_rd, 8'h44);
    wr(0, 8'h48, "R12");

    // R11 rotating EOIs and ignored codes
    wr(1, 8'h00, "R11"); wr(0, 8'h40, "R11"); wr(0, 8'h80, "R11");
    rd(0, "R11"); chk("R11", last_rd, 8'h44);
    wr(0, 8'hA0, "R11"); rd(0, "R11"); chk("R11", last_rd, 8'h40);
    wr(0, 8'hE6, "R11"); rd(0, "R11"); chk("R11", last_rd, 8'h00);
    m_req = 8'hC5; idle(3, "R11");
    wr(0, 8'h0C, "R11"); rd(0, "R11"); chk("R11", last_rd, 8'h87);
    rd(0, "R13"); chk("R13", last_rd, 8'h80);
    m_req = 8'h00; wr(0, 8'h20, "R10"); idle(2, "R3");

    // random traffic against the model
    for (int it = 0; it < 3000; it++) begin
      int unsigned op;
      op = $urandom_range(0, 15);
      case (op)
        0, 1, 2, 3, 4: idle(1, "R3");
        5:  wr(1, ($urandom_range(0, 1) != 0) ? 8'h00 : 8'($urandom()), "R4");
        6:  wr(0, 8'h0C, "R6");
        7, 8: rd(0, "R6");
        9:  rd(1, "R4");
        10: wr(0, 8'h0A | 8'($urandom_range(0, 1)), "R7");
        11: wr(0, {3'($urandom()), 2'b00, 3'($urandom())}, "R11");
        12: wr(0, ($urandom_range(0, 1) != 0) ? 8'h68 : 8'h48, "R12");
        13: if ($urandom_range(0, 7) == 0) begin
              bit m4;
              m4 = 1'($urandom_range(0, 1));
              wr(0, 8'h10 | 8'(m4), "R2");
              wr(1, 8'($urandom()), "R2");
              wr(1, 8'($urandom()), "R2");
              if (m4) wr(1, 8'($urandom()), "R2");
            end else idle(1, "R14");
        default: begin
          m_req[$urandom_range(0, 7)] ^= 1'b1;
          idle(1, "R3");
        end
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: run did not complete, all requirements");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

endmodule